// File: doc/BRIEF.md
# Class-Pair Pipeline Interlock

This block decides, cycle by cycle, whether the next instruction of an in-order pipeline may issue. The front end presents the instruction at the head of the issue stream (its class, destination and up to two source registers) together with a look-ahead copy of the instruction behind it. The block keeps a small per-register scoreboard. For each register it records how many cycles have gone by since an instruction last wrote it, and which class that writer had. A consumer is held while any of its sources was written too recently for the pair of producer class and consumer class. The required gap for each pair comes from a fixed latency table, so the block models execution timing without carrying data or forwarding paths.

Branches have one architectural delay slot, and the slot instruction must issue in the cycle right after its branch. The block therefore issues a branch only when both conditions hold: the branch's own sources are ready, and the slot instruction's sources will be ready one cycle later. The slot instruction then issues without a check. When no slot instruction is supplied with the branch, the following cycle becomes a bubble. The front end advances its stream on every cycle in which `issue_o` is high.

Top module: `ilk_unit`

## Requirements
- R1: Classes are encoded on 3 bits: 0 no-op, 1 integer ALU, 2 FP ALU, 3 load double, 4 store double, 5 branch. Only classes 1, 2 and 3 write their destination. After a synchronous active-high reset, every register counts as long settled, no writer from before the reset delays any instruction, and both outputs are low while no instruction is offered.
- R2: A consumer in the FP ALU class that reads the result of an FP ALU instruction issues no earlier than 4 cycles after that instruction, which leaves 3 stall cycles.
- R3: A store double that reads an FP ALU result issues no earlier than 3 cycles after it, which leaves 2 stall cycles.
- R4: An FP ALU instruction that reads a load-double result waits 1 stall cycle. A store double that reads a load-double result issues in the very next cycle.
- R5: An integer ALU instruction that reads an integer result issues in the next cycle. A branch that reads an integer result waits 1 stall cycle.
- R6: Register index 0 never delays any instruction, whether it is read or written.
- R7: Elapsed time per register advances every cycle. This includes stall cycles and cycles with no instruction offered.
- R8: A branch issues only in a cycle where its slot instruction would have no hazard in the next cycle. The slot instruction then issues in the cycle right after the branch.
- R9: A branch that issues while no look-ahead instruction is marked valid makes the next cycle a bubble. In that cycle nothing issues and `stall_o` is high, even if an instruction is offered.
- R10: `issue_o` is high only when an instruction is offered. `stall_o` is high exactly when an offered instruction is held or a bubble fills the slot. The two outputs are never high together.
- R11: Over repeated iterations, the unscheduled scalar-add loop (load, FP add, store, pointer decrement, branch, no-op in the slot) takes 10 cycles per iteration. The scheduled version (load, decrement, FP add, branch, store in the slot) takes 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_vld_i | input | 1 | An instruction is offered for issue |
| cur_cls_i | input | 3 | Class of the offered instruction |
| cur_dst_i | input | REG_W | Destination register of the offered instruction |
| cur_src_a_i | input | REG_W | First source register (0 when unused) |
| cur_src_b_i | input | REG_W | Second source register (0 when unused) |
| nxt_vld_i | input | 1 | The look-ahead instruction is valid |
| nxt_cls_i | input | 3 | Class of the look-ahead instruction |
| nxt_src_a_i | input | REG_W | First source of the look-ahead instruction |
| nxt_src_b_i | input | REG_W | Second source of the look-ahead instruction |
| issue_o | output | 1 | The offered instruction issues this cycle |
| stall_o | output | 1 | A stall or bubble occupies this cycle |

## Verification
A wrong elapsed count or a wrong producer class in one scoreboard entry becomes visible at the ports the next time that register is read. The consumer issues one or more cycles early or late, and the per-cycle comparison catches it in that same cycle. A wrong slot state shows up in the cycle right after a branch, either as a missing slot issue or as a missing bubble. The loop replays are there to expose errors that pile up across iterations, because any extra stall changes the spacing between successive loads.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  localparam int MAX_LAT = 3;
  localparam int LAT_W   = $clog2(MAX_LAT + 1);

  typedef enum logic [2:0] {
    CLS_NOP = 3'd0,
    CLS_INT = 3'd1,
    CLS_FPU = 3'd2,
    CLS_LDD = 3'd3,
    CLS_STD = 3'd4,
    CLS_BRA = 3'd5
  } icls_e;

  typedef enum logic [1:0] {
    SL_NONE   = 2'd0,
    SL_ISSUE  = 2'd1,
    SL_BUBBLE = 2'd2
  } slot_e;

  // required stall cycles between a producer class and a consumer class
  function automatic logic [LAT_W-1:0] pair_lat(input logic [2:0] prod, input logic [2:0] cons);
    logic [LAT_W-1:0] r;
    r = '0;
    case (prod)
      CLS_FPU: begin
        if (cons == CLS_FPU)      r = LAT_W'(3);
        else if (cons == CLS_STD) r = LAT_W'(2);
      end
      CLS_LDD: begin
        if (cons != CLS_STD && cons != CLS_NOP) r = LAT_W'(1);
      end
      CLS_INT: begin
        if (cons == CLS_BRA) r = LAT_W'(1);
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic writes_reg(input logic [2:0] c);
    return (c == CLS_INT) || (c == CLS_FPU) || (c == CLS_LDD);
  endfunction

endpackage

// File: rtl/ilk_regtrack.sv
module ilk_regtrack
  import ilk_pkg::*;
#(
  parameter int REG_W = 6,
  parameter int AGE_W = 2,
  parameter int NRD   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_idx,
  input  logic [2:0]       wr_cls,
  input  logic [REG_W-1:0] rd_idx [NRD],
  output logic [AGE_W-1:0] rd_age [NRD],
  output logic [2:0]       rd_cls [NRD]
);

  localparam int NREG = 1 << REG_W;

  logic [AGE_W-1:0] age_q [NREG];
  logic [2:0]       cls_q [NREG];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (rst) begin
        age_q[i] <= '1;
        cls_q[i] <= CLS_NOP;
      end else if (wr_en && wr_idx == REG_W'(i)) begin
        age_q[i] <= '0;
        cls_q[i] <= wr_cls;
      end else if (age_q[i] != '1) begin
        age_q[i] <= age_q[i] + AGE_W'(1);
      end
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_age[g] = age_q[rd_idx[g]];
    assign rd_cls[g] = cls_q[rd_idx[g]];
  end

endmodule

// File: rtl/ilk_pair_check.sv
module ilk_pair_check
  import ilk_pkg::*;
#(
  parameter int REG_W = 6,
  parameter int AGE_W = 2,
  parameter int LOOK  = 0
) (
  input  logic [REG_W-1:0] idx,
  input  logic [AGE_W-1:0] age,
  input  logic [2:0]       prod_cls,
  input  logic [2:0]       cons_cls,
  output logic             hit
);

  localparam int EW = AGE_W + 2;

  logic [EW-1:0] need;
  logic [EW-1:0] seen;

  always_comb begin
    need = EW'(pair_lat(prod_cls, cons_cls));
    seen = EW'(age) + EW'(LOOK);
    hit  = (idx != '0) && (seen < need);
  end

endmodule

// File: rtl/ilk_unit.sv
module ilk_unit
  import ilk_pkg::*;
#(
  parameter int REG_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cur_vld_i,
  input  logic [2:0]       cur_cls_i,
  input  logic [REG_W-1:0] cur_dst_i,
  input  logic [REG_W-1:0] cur_src_a_i,
  input  logic [REG_W-1:0] cur_src_b_i,
  input  logic             nxt_vld_i,
  input  logic [2:0]       nxt_cls_i,
  input  logic [REG_W-1:0] nxt_src_a_i,
  input  logic [REG_W-1:0] nxt_src_b_i,
  output logic             issue_o,
  output logic             stall_o
);

  localparam int NRD   = 4;
  localparam int AGE_W = LAT_W;

  logic [REG_W-1:0] rd_idx  [NRD];
  logic [AGE_W-1:0] rd_age  [NRD];
  logic [2:0]       rd_cls  [NRD];
  logic [NRD-1:0]   hit;

  slot_e slot_q, slot_d;
  logic  go, bub, cur_haz, nxt_haz, is_br, wr_en;

  assign rd_idx[0] = cur_src_a_i;
  assign rd_idx[1] = cur_src_b_i;
  assign rd_idx[2] = nxt_src_a_i;
  assign rd_idx[3] = nxt_src_b_i;

  ilk_regtrack #(.REG_W(REG_W), .AGE_W(AGE_W), .NRD(NRD)) u_track (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_idx (cur_dst_i),
    .wr_cls (cur_cls_i),
    .rd_idx (rd_idx),
    .rd_age (rd_age),
    .rd_cls (rd_cls)
  );

  // ports 0/1 check the offered instruction now; ports 2/3 check the
  // slot candidate one cycle ahead
  for (genvar g = 0; g < NRD; g++) begin : g_chk
    if (g < 2) begin : g_now
      ilk_pair_check #(.REG_W(REG_W), .AGE_W(AGE_W), .LOOK(0)) u_pc (
        .idx (rd_idx[g]), .age (rd_age[g]), .prod_cls (rd_cls[g]),
        .cons_cls (cur_cls_i), .hit (hit[g])
      );
    end else begin : g_ahead
      ilk_pair_check #(.REG_W(REG_W), .AGE_W(AGE_W), .LOOK(1)) u_pc (
        .idx (rd_idx[g]), .age (rd_age[g]), .prod_cls (rd_cls[g]),
        .cons_cls (nxt_cls_i), .hit (hit[g])
      );
    end
  end

  always_comb begin
    cur_haz = hit[0] | hit[1];
    nxt_haz = nxt_vld_i & (hit[2] | hit[3]);
    is_br   = (cur_cls_i == CLS_BRA);
    go      = 1'b0;
    bub     = 1'b0;
    slot_d  = SL_NONE;
    case (slot_q)
      SL_ISSUE:  go  = cur_vld_i;
      SL_BUBBLE: bub = 1'b1;
      default: begin
        go = cur_vld_i & ~cur_haz & ~(is_br & nxt_haz);
        if (go && is_br) slot_d = nxt_vld_i ? SL_ISSUE : SL_BUBBLE;
      end
    endcase
    issue_o = go & ~rst;
    stall_o = ~rst & (bub | ((slot_q == SL_NONE) & cur_vld_i & ~go));
    wr_en   = issue_o & writes_reg(cur_cls_i) & (cur_dst_i != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) slot_q <= SL_NONE;
    else     slot_q <= slot_d;
  end

endmodule

// File: rtl/ilk_unit_chk.sv
module ilk_unit_chk #(
  parameter int REG_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             cur_vld_i,
  input logic [2:0]       cur_cls_i,
  input logic [REG_W-1:0] cur_dst_i,
  input logic [REG_W-1:0] cur_src_a_i,
  input logic [REG_W-1:0] cur_src_b_i,
  input logic             nxt_vld_i,
  input logic             issue_o,
  input logic             stall_o
);

  logic in_slot;

  always_ff @(posedge clk) begin
    if (rst) in_slot <= 1'b0;
    else     in_slot <= issue_o && cur_cls_i == 3'd5 && !in_slot;
  end

  // R10
  issue_gate_chk: assert property (@(posedge clk) disable iff (rst)
    issue_o |-> cur_vld_i);

  // R10
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(issue_o && stall_o));

  // R8
  slot_go_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_o && cur_cls_i == 3'd5 && nxt_vld_i && !in_slot)
      |=> (issue_o == cur_vld_i) && !stall_o);

  // R9
  slot_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_o && cur_cls_i == 3'd5 && !nxt_vld_i && !in_slot)
      |=> (!issue_o && stall_o));

  // R2
  fp_chain_gap_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(issue_o && cur_cls_i == 3'd2 && cur_dst_i != '0) && issue_o && cur_cls_i == 3'd2)
      |-> (cur_src_a_i != $past(cur_dst_i) && cur_src_b_i != $past(cur_dst_i)));

endmodule

bind ilk_unit ilk_unit_chk #(.REG_W(REG_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cur_vld_i   (cur_vld_i),
  .cur_cls_i   (cur_cls_i),
  .cur_dst_i   (cur_dst_i),
  .cur_src_a_i (cur_src_a_i),
  .cur_src_b_i (cur_src_b_i),
  .nxt_vld_i   (nxt_vld_i),
  .issue_o     (issue_o),
  .stall_o     (stall_o)
);

// File: tb/ilk_unit_test.sv
module ilk_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int RW = 6;
  localparam int NOP = 0, INT = 1, FPU = 2, LDD = 3, STD = 4, BRA = 5;
  localparam int F = 32;  // FP registers start at index 32

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic          cur_vld = 1'b0, nxt_vld = 1'b0;
  logic [2:0]    cur_cls = '0, nxt_cls = '0;
  logic [RW-1:0] cur_dst = '0, cur_a = '0, cur_b = '0, nxt_a = '0, nxt_b = '0;
  logic          issue_o, stall_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  ilk_unit #(.REG_W(RW)) uut (
    .clk (clk), .rst (rst),
    .cur_vld_i (cur_vld), .cur_cls_i (cur_cls), .cur_dst_i (cur_dst),
    .cur_src_a_i (cur_a), .cur_src_b_i (cur_b),
    .nxt_vld_i (nxt_vld), .nxt_cls_i (nxt_cls),
    .nxt_src_a_i (nxt_a), .nxt_src_b_i (nxt_b),
    .issue_o (issue_o), .stall_o (stall_o)
  );

  typedef struct { int vld; int cls; int dst; int sa; int sb; int hide; } ins_t;

  ins_t prog[$];
  int   iss_at[$];
  int   tests = 0, fails = 0;
  int   cyc = 0;
  int   last_w [64];
  int   last_c [64];
  bit   done = 0;

  task automatic chk(string r, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  function automatic int lat_of(int p, int c);
    if (p == FPU && c == FPU) return 3;
    if (p == FPU && c == STD) return 2;
    if (p == LDD && c != STD && c != NOP) return 1;
    if (p == INT && c == BRA) return 1;
    return 0;
  endfunction

  function automatic bit src_late(int s, int c, int k);
    if (s == 0) return 0;
    return (cyc + k - last_w[s] - 1) < lat_of(last_c[s], c);
  endfunction

  task automatic add(int cls, int dst, int sa, int sb, int hide = 0);
    ins_t t;
    t.vld = 1; t.cls = cls; t.dst = dst; t.sa = sa; t.sb = sb; t.hide = hide;
    prog.push_back(t);
  endtask

  task automatic hole();
    ins_t t;
    t.vld = 0; t.cls = 0; t.dst = 0; t.sa = 0; t.sb = 0; t.hide = 0;
    prog.push_back(t);
  endtask

  task automatic model_clear();
    for (int i = 0; i < 64; i++) begin last_w[i] = -1000; last_c[i] = NOP; end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cur_vld = 1'b0; nxt_vld = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_clear();
    #1;
    chk("R1 reset issue", int'(issue_o), 0);
    chk("R1 reset stall", int'(stall_o), 0);
  endtask

  // drive the queued program, comparing with the reference every cycle
  task automatic run_prog();
    int pc = 0, mode = 0, lim = 0;
    iss_at = {};
    for (int i = 0; i < prog.size(); i++) iss_at.push_back(-1);
    while (pc < prog.size() || mode != 0) begin
      int e_iss, e_stall, nmode;
      bit haz;
      @(negedge clk);
      if (pc < prog.size()) begin
        cur_vld = prog[pc].vld[0]; cur_cls = 3'(prog[pc].cls);
        cur_dst = RW'(prog[pc].dst); cur_a = RW'(prog[pc].sa); cur_b = RW'(prog[pc].sb);
      end else begin
        cur_vld = 1'b0; cur_cls = '0; cur_dst = '0; cur_a = '0; cur_b = '0;
      end
      if (pc + 1 < prog.size() && prog[pc].hide == 0) begin
        nxt_vld = prog[pc+1].vld[0]; nxt_cls = 3'(prog[pc+1].cls);
        nxt_a = RW'(prog[pc+1].sa); nxt_b = RW'(prog[pc+1].sb);
      end else begin
        nxt_vld = 1'b0; nxt_cls = '0; nxt_a = '0; nxt_b = '0;
      end
      #1;
      nmode = 0;
      if (mode == 2) begin
        e_iss = 0; e_stall = 1;
      end else if (mode == 1) begin
        e_iss = int'(cur_vld); e_stall = 0;
      end else if (cur_vld) begin
        haz = src_late(int'(cur_a), int'(cur_cls), 0) | src_late(int'(cur_b), int'(cur_cls), 0);
        if (cur_cls == 3'(BRA) && nxt_vld)
          haz |= src_late(int'(nxt_a), int'(nxt_cls), 1) | src_late(int'(nxt_b), int'(nxt_cls), 1);
        e_iss = haz ? 0 : 1; e_stall = haz ? 1 : 0;
        if (e_iss == 1 && cur_cls == 3'(BRA)) nmode = nxt_vld ? 1 : 2;
      end else begin
        e_iss = 0; e_stall = 0;
      end
      chk("R10 issue per cycle", int'(issue_o), e_iss);
      chk("R10 stall per cycle", int'(stall_o), e_stall);
      if (e_iss == 1) begin
        int c = int'(cur_cls);
        if ((c == INT || c == FPU || c == LDD) && cur_dst != 0) begin
          last_w[cur_dst] = cyc; last_c[cur_dst] = c;
        end
        iss_at[pc] = cyc;
        pc++;
      end else if (pc < prog.size() && prog[pc].vld == 0 && mode == 0) begin
        pc++;
      end
      mode = nmode;
      cyc++;
      lim++;
      if (lim > 2000) begin
        chk("watchdog program stuck", lim, 0);
        break;
      end
    end
    @(negedge clk);
    cur_vld = 1'b0; nxt_vld = 1'b0;
    cyc++;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    model_clear();
    do_reset();

    // R2: FP to FP
    prog = {}; add(FPU, F+4, F+0, F+2); add(FPU, F+6, F+4, F+2); run_prog();
    chk("R2 fp->fp gap", iss_at[1] - iss_at[0], 4);

    // R3: FP to store
    prog = {}; add(FPU, F+8, F+0, F+2); add(STD, 0, 1, F+8); run_prog();
    chk("R3 fp->store gap", iss_at[1] - iss_at[0], 3);

    // R4: load to FP and load to store
    prog = {}; add(LDD, F+10, 1, 0); add(FPU, F+12, F+10, F+2);
    add(LDD, F+14, 1, 0); add(STD, 0, 1, F+14); run_prog();
    chk("R4 load->fp gap", iss_at[1] - iss_at[0], 2);
    chk("R4 load->store gap", iss_at[3] - iss_at[2], 1);

    // R5 and R8: integer chains, branch with no-op slot
    prog = {}; add(INT, 2, 1, 0); add(INT, 3, 2, 0); add(INT, 4, 3, 0);
    add(BRA, 0, 4, 0); add(NOP, 0, 0, 0); run_prog();
    chk("R5 int->int gap", iss_at[1] - iss_at[0], 1);
    chk("R5 int->branch gap", iss_at[3] - iss_at[2], 2);
    chk("R8 slot follows branch", iss_at[4] - iss_at[3], 1);

    // R6: register 0 written and read
    prog = {}; add(FPU, 0, F+2, 0); add(FPU, F+16, 0, 0);
    add(LDD, 0, 1, 0); add(FPU, F+18, 0, F+2); run_prog();
    chk("R6 fp write r0", iss_at[1] - iss_at[0], 1);
    chk("R6 load write r0", iss_at[3] - iss_at[2], 1);

    // R7: ageing during stalls and idle cycles
    prog = {}; add(LDD, F+20, 1, 0); add(FPU, F+22, F+2, 0);
    add(FPU, F+24, F+22, 0); add(FPU, F+26, F+20, 0); run_prog();
    chk("R7 stall wait", iss_at[2] - iss_at[1], 4);
    chk("R7 aged during stalls", iss_at[3] - iss_at[2], 1);
    prog = {}; add(FPU, F+28, F+2, 0); hole(); hole(); hole();
    add(FPU, F+30, F+28, 0); run_prog();
    chk("R7 aged while idle", iss_at[4] - iss_at[0], 4);

    // R8: branch held until its slot store is ready
    prog = {}; add(FPU, F+4, F+0, F+2); add(BRA, 0, 5, 0); add(STD, 0, 1, F+4); run_prog();
    chk("R8 branch held for slot", iss_at[1] - iss_at[0], 2);
    chk("R8 slot store issues", iss_at[2] - iss_at[1], 1);

    // R9: branch without look-ahead -> bubble, offered instruction waits
    prog = {}; add(INT, 2, 1, 0); add(BRA, 0, 2, 0, 1); add(INT, 3, 0, 0); run_prog();
    chk("R9 branch stall", iss_at[1] - iss_at[0], 2);
    chk("R9 bubble then issue", iss_at[2] - iss_at[1], 2);

    // R1: reset clears a pending writer
    prog = {}; add(FPU, F+6, F+0, F+2); run_prog();
    do_reset();
    prog = {}; add(FPU, F+8, F+6, F+6); run_prog();
    chk("R1 no stall after reset", iss_at[0] >= 0 ? 1 : 0, 1);
    chk("R1 no stall count", int'(stall_o), 0);

    // R11: unscheduled loop
    prog = {};
    for (int it = 0; it < 3; it++) begin
      add(LDD, F+0, 1, 0); add(FPU, F+4, F+0, F+2); add(STD, 0, 1, F+4);
      add(INT, 1, 1, 0); add(BRA, 0, 1, 0); add(NOP, 0, 0, 0);
    end
    run_prog();
    chk("R11 unscheduled iter 1", iss_at[6] - iss_at[0], 10);
    chk("R11 unscheduled iter 2", iss_at[12] - iss_at[6], 10);

    // R11: scheduled loop
    prog = {};
    for (int it = 0; it < 3; it++) begin
      add(LDD, F+0, 1, 0); add(INT, 1, 1, 0); add(FPU, F+4, F+0, F+2);
      add(BRA, 0, 1, 0); add(STD, 0, 1, F+4);
    end
    run_prog();
    chk("R11 scheduled iter 1", iss_at[5] - iss_at[0], 6);
    chk("R11 scheduled iter 2", iss_at[10] - iss_at[5], 6);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule